// File: doc/BRIEF.md
# Windowed Register File

This block is a register file that gives software 32 register numbers at a time. Eight of them are global and the same in every context. The other 24 come from a circular ring of windows, and a current window pointer selects which window is visible. Each window has eight private locals. Its eight outgoing registers are the same physical storage as the eight incoming registers of the window that a call moves into. A caller places arguments in its outs, strobes save, and the callee finds them in its ins. Results travel back the same way on restore.

The block has two combinational read ports and one write port. All three are addressed by 5-bit register numbers, and each port translates its number to a physical slot through the current window pointer. The number of windows is a parameter from 3 to 32, and the physical storage holds 8 + 16×NWIN words. The pointer comes out of reset at 0. A marker one step above that position stands for the oldest live frame. A save that would land on the marker reports overflow, and so does a restore that would land on it. In both cases the pointer stays where it was.

Top module: `winreg_file`

## Requirements
- R1: Register numbers 0–7 are globals: the same physical registers whatever the window pointer is.
- R2: Register 0 always reads 0 on both read ports, and a write to it is discarded.
- R3: Numbers 8–15 are the window's outs, 16–23 its locals and 24–31 its ins. Ins of window w are the outs of window (w+1) mod NWIN, including the wrap from window NWIN-1 to window 0.
- R4: Locals are private to a window. A local written in one window keeps its value across a save and a matching restore, and is not visible from another window.
- R5: A save strobe alone moves the pointer to (p-1) mod NWIN. A restore strobe alone moves it to (p+1) mod NWIN. The pointer is always below NWIN and is output on `cwp_o`.
- R6: After reset the pointer is 0, every register reads 0, and both flags are low.
- R7: A save whose target equals the marker ((reset pointer + 1) mod NWIN, which is 1) drives `ovf_o` high in that same cycle and leaves the pointer unchanged.
- R8: A restore whose target equals the marker drives `unf_o` high in that same cycle and leaves the pointer unchanged.
- R9: Reads are combinational and a write takes effect at the clock edge, so a read in the cycle of a write to the same register returns the old value.
- R10: A write in the same cycle as a save is translated through the pre-save window.
- R11: Save and restore strobed together leave the pointer unchanged and raise neither flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 5 | Register number, read port A |
| rd_b_idx | input | 5 | Register number, read port B |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Register number, write port |
| wr_data | input | DATA_W | Write data |
| save_i | input | 1 | Move to the callee window |
| restore_i | input | 1 | Move back to the caller window |
| rd_a_data | output | DATA_W | Read data, port A |
| rd_b_data | output | DATA_W | Read data, port B |
| cwp_o | output | 5 | Current window pointer |
| ovf_o | output | 1 | Save refused at the marker |
| unf_o | output | 1 | Restore refused at the marker |

## Verification
A wrong window pointer shows on `cwp_o` one edge after the strobe. In the next read of a windowed register it also shows as another window's value. A wrong overlap mapping stays hidden until the callee reads an incoming register. That first read returns zero or a stale value in place of the argument, including across the wrap at the last window. A refused strobe that still moves the pointer shows on `cwp_o` at the following edge, and the same flag rises one transfer too early or too late.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

  localparam int unsigned ARCH_W = 5;
  localparam int unsigned GROUP  = 8;

  // step the pointer toward the callee, wrapping at zero
  function automatic logic [4:0] ptr_dec(input logic [4:0] p, input int unsigned nwin);
    return (p == 5'd0) ? 5'(nwin - 1) : p - 5'd1;
  endfunction

  // step the pointer toward the caller, wrapping at nwin-1
  function automatic logic [4:0] ptr_inc(input logic [4:0] p, input int unsigned nwin);
    return (p == 5'(nwin - 1)) ? 5'd0 : p + 5'd1;
  endfunction

  // physical slot: globals 0..7, then per window 8 locals followed by 8 outs
  function automatic int unsigned phys_of(input logic [4:0] p, input logic [4:0] arch,
                                          input int unsigned nwin);
    int unsigned w;
    int unsigned k;
    w = int'(p);
    k = int'(arch[2:0]);
    case (arch[4:3])
      2'd0:    return k;
      2'd1:    return 16 + 16 * w + k;
      2'd2:    return 8 + 16 * w + k;
      default: return 16 + 16 * int'(ptr_inc(p, nwin)) + k;
    endcase
  endfunction

endpackage

// File: rtl/wrf_window_ctl.sv
module wrf_window_ctl #(
  parameter int unsigned NWIN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       save_i,
  input  logic       restore_i,
  output logic [4:0] cwp_o,
  output logic       ovf_o,
  output logic       unf_o
);
  localparam logic [4:0] RESET_PTR = 5'd0;
  localparam logic [4:0] MARKER    = wrf_pkg::ptr_inc(RESET_PTR, NWIN);

  logic [4:0] cwp_q;
  logic [4:0] dec_tgt;
  logic [4:0] inc_tgt;
  logic       go_save;
  logic       go_rest;

  assign dec_tgt = wrf_pkg::ptr_dec(cwp_q, NWIN);
  assign inc_tgt = wrf_pkg::ptr_inc(cwp_q, NWIN);
  assign go_save = save_i & ~restore_i;
  assign go_rest = restore_i & ~save_i;
  assign ovf_o   = go_save & (dec_tgt == MARKER);
  assign unf_o   = go_rest & (inc_tgt == MARKER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q <= RESET_PTR;
    end else if (go_save && !ovf_o) begin
      cwp_q <= dec_tgt;
    end else if (go_rest && !unf_o) begin
      cwp_q <= inc_tgt;
    end
  end

  assign cwp_o = cwp_q;

  assert_ptr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cwp_q) < NWIN);
  assert_ovf_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> $stable(cwp_q));
  assert_unf_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    unf_o |=> $stable(cwp_q));
  assert_dual_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (save_i && restore_i) |=> $stable(cwp_q));
  assert_flags_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_o && unf_o));

endmodule

// File: rtl/wrf_xlate.sv
module wrf_xlate #(
  parameter int unsigned NWIN = 8,
  parameter int unsigned PW   = 8
) (
  input  logic [4:0]    cwp_i,
  input  logic [4:0]    arch_i,
  output logic [PW-1:0] phys_o
);
  assign phys_o = PW'(wrf_pkg::phys_of(cwp_i, arch_i, NWIN));
endmodule

// File: rtl/wrf_storage.sv
module wrf_storage #(
  parameter int unsigned DEPTH  = 136,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PW-1:0]     wr_phys,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PW-1:0]     ra_phys,
  input  logic [PW-1:0]     rb_phys,
  output logic [DATA_W-1:0] ra_data,
  output logic [DATA_W-1:0] rb_data
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic              wr_live;

  // slot 0 is the hard zero global and never accepts a write
  assign wr_live = wr_en && (wr_phys != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
    end else if (wr_live) begin
      mem[wr_phys] <= wr_data;
    end
  end

  assign ra_data = mem[ra_phys];
  assign rb_data = mem[rb_phys];

endmodule

// File: rtl/winreg_file.sv
module winreg_file #(
  parameter int unsigned NWIN   = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        rd_a_idx,
  input  logic [4:0]        rd_b_idx,
  input  logic              wr_en,
  input  logic [4:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              save_i,
  input  logic              restore_i,
  output logic [DATA_W-1:0] rd_a_data,
  output logic [DATA_W-1:0] rd_b_data,
  output logic [4:0]        cwp_o,
  output logic              ovf_o,
  output logic              unf_o
);
  localparam int unsigned DEPTH  = wrf_pkg::GROUP + 2 * wrf_pkg::GROUP * NWIN;
  localparam int unsigned PW     = $clog2(DEPTH);
  localparam int unsigned NPORTS = 3;

  logic [4:0]    cwp;
  logic [4:0]    arch_idx [NPORTS];
  logic [PW-1:0] phys_idx [NPORTS];

  wrf_window_ctl #(.NWIN(NWIN)) u_ctl (
    .clk(clk), .rst_n(rst_n), .save_i(save_i), .restore_i(restore_i),
    .cwp_o(cwp), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  // port 0 write, 1 read A, 2 read B; all use the pointer before any strobe
  assign arch_idx[0] = wr_idx;
  assign arch_idx[1] = rd_a_idx;
  assign arch_idx[2] = rd_b_idx;

  for (genvar g = 0; g < int'(NPORTS); g++) begin : g_xl
    wrf_xlate #(.NWIN(NWIN), .PW(PW)) u_xl (
      .cwp_i(cwp), .arch_i(arch_idx[g]), .phys_o(phys_idx[g])
    );
  end

  wrf_storage #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PW(PW)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_phys(phys_idx[0]),
    .wr_data(wr_data), .ra_phys(phys_idx[1]), .rb_phys(phys_idx[2]),
    .ra_data(rd_a_data), .rb_data(rd_b_data)
  );

  assign cwp_o = cwp;

  assert_g0_zero_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 5'd0) |-> (rd_a_data == '0));
  assert_g0_zero_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_idx == 5'd0) |-> (rd_b_data == '0));
  assert_phys_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(phys_idx[1]) < DEPTH) && (int'(phys_idx[2]) < DEPTH));

endmodule

// File: tb/winreg_file_bench.sv
module winreg_file_bench;
  localparam int unsigned NW = 4;
  localparam int unsigned DW = 32;

  typedef struct packed {
    logic       sv;
    logic       rs;
    logic       we;
    logic [4:0] widx;
    logic [31:0] wdat;
    logic [4:0] ridx;
    logic [31:0] exp_rd;
    logic [4:0] exp_cwp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b1, 5'd8,  32'h11,       5'd8,  32'h0,  5'd0},
    '{1'b0, 1'b0, 1'b1, 5'd16, 32'h22,       5'd8,  32'h11, 5'd0},
    '{1'b1, 1'b0, 1'b1, 5'd9,  32'h33,       5'd16, 32'h22, 5'd0},
    '{1'b0, 1'b0, 1'b1, 5'd16, 32'h44,       5'd24, 32'h11, 5'd3},
    '{1'b0, 1'b0, 1'b1, 5'd1,  32'h55,       5'd25, 32'h33, 5'd3},
    '{1'b0, 1'b1, 1'b0, 5'd0,  32'h0,        5'd16, 32'h44, 5'd3},
    '{1'b0, 1'b0, 1'b1, 5'd0,  32'hDEAD,     5'd1,  32'h55, 5'd0},
    '{1'b0, 1'b0, 1'b0, 5'd0,  32'h0,        5'd16, 32'h22, 5'd0},
    '{1'b0, 1'b0, 1'b0, 5'd0,  32'h0,        5'd0,  32'h0,  5'd0}
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 1:    return "R9 read old value in write cycle";
      2:       return "R4 local kept";
      3:       return "R3 ins of last window are outs of window 0";
      4:       return "R10 write with save used pre-save window";
      5:       return "R4 local of callee";
      6:       return "R1 global seen across windows";
      7:       return "R4 local kept after restore";
      default: return "R2 register 0 write discarded";
    endcase
  endfunction

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic          wr_en = 1'b0, save_i = 1'b0, restore_i = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_a_data, rd_b_data;
  logic [4:0]    cwp_o;
  logic          ovf_o, unf_o;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #2.5 clk = ~clk;

  winreg_file #(.NWIN(NW), .DATA_W(DW)) u_winreg_file (
    .clk(clk), .rst_n(rst_n), .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .save_i(save_i),
    .restore_i(restore_i), .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
    .cwp_o(cwp_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one cycle's inputs at the falling edge, then settle before sampling
  task automatic drive(input logic sv, input logic rs, input logic we,
                       input logic [4:0] wi, input logic [31:0] wd,
                       input logic [4:0] ra, input logic [4:0] rb);
    @(negedge clk);
    save_i = sv; restore_i = rs; wr_en = we; wr_idx = wi; wr_data = wd;
    rd_a_idx = ra; rd_b_idx = rb;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R6 pointer after reset", 32'(cwp_o), 32'd0);
    chk("R6 overflow low after reset", 32'(ovf_o), 32'd0);
    chk("R6 underflow low after reset", 32'(unf_o), 32'd0);
    rd_a_idx = 5'd8; rd_b_idx = 5'd31;
    #0.5;
    chk("R6 out reg zero after reset", rd_a_data, 32'd0);
    chk("R6 in reg zero after reset", rd_b_data, 32'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].sv, VECS[i].rs, VECS[i].we, VECS[i].widx, VECS[i].wdat,
            VECS[i].ridx, 5'd0);
      chk(tag_of(i), rd_a_data, VECS[i].exp_rd);
      chk("R5 pointer in table walk", 32'(cwp_o), 32'(VECS[i].exp_cwp));
      chk("R2 port B register 0", rd_b_data, 32'd0);
    end

    // R11: both strobes together
    drive(1'b1, 1'b1, 1'b0, 5'd0, 32'd0, 5'd0, 5'd0);
    chk("R11 no overflow on dual strobe", 32'(ovf_o), 32'd0);
    chk("R11 no underflow on dual strobe", 32'(unf_o), 32'd0);
    drive(1'b1, 1'b0, 1'b0, 5'd0, 32'd0, 5'd1, 5'd16);
    chk("R11 pointer held on dual strobe", 32'(cwp_o), 32'd0);
    chk("R5 save from 0 not refused", 32'(ovf_o), 32'd0);
    drive(1'b1, 1'b0, 1'b0, 5'd0, 32'd0, 5'd1, 5'd16);
    chk("R5 save wraps to NWIN-1", 32'(cwp_o), 32'd3);
    chk("R1 global from window 3", rd_a_data, 32'h55);
    chk("R4 window 3 local on port B", rd_b_data, 32'h44);
    drive(1'b1, 1'b0, 1'b0, 5'd0, 32'd0, 5'd16, 5'd24);
    chk("R5 second save", 32'(cwp_o), 32'd2);
    chk("R4 window 2 local distinct", rd_a_data, 32'd0);
    chk("R7 overflow at marker", 32'(ovf_o), 32'd1);
    drive(1'b0, 1'b1, 1'b0, 5'd0, 32'd0, 5'd0, 5'd0);
    chk("R7 pointer held after overflow", 32'(cwp_o), 32'd2);
    chk("R8 restore from 2 not refused", 32'(unf_o), 32'd0);
    drive(1'b0, 1'b1, 1'b0, 5'd0, 32'd0, 5'd0, 5'd0);
    chk("R5 restore step", 32'(cwp_o), 32'd3);
    drive(1'b0, 1'b1, 1'b0, 5'd0, 32'd0, 5'd16, 5'd0);
    chk("R5 restore wraps to 0", 32'(cwp_o), 32'd0);
    chk("R4 window 0 local after round trip", rd_a_data, 32'h22);
    chk("R8 underflow at marker", 32'(unf_o), 32'd1);
    drive(1'b0, 1'b0, 1'b0, 5'd0, 32'd0, 5'd8, 5'd0);
    chk("R8 pointer held after underflow", 32'(cwp_o), 32'd0);
    chk("R3 window 0 out kept", rd_a_data, 32'h11);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule